// File: doc/BRIEF.md
# Discharge Duration Timer with Overflow Rate Step-Down

This block measures how long a battery spends discharging. A comparator elsewhere raises `dsg_active` whenever the sense voltage sits below its reference. Two time-base strobes arrive from a shared prescaler. `tick_fast` pulses 4096 times per hour and `tick_slow` pulses 16 times per hour. While discharge is flagged, the timer adds one on each pulse of whichever strobe is currently selected.

A plain wrap on overflow would lose the accumulated time. Instead, the first pass beyond the all-ones value raises a `slow_rate` status flag, and from then on the count follows the slow strobe. This stretches the span the timer can cover by a factor of 256. A second overflow drops the flag, so counting returns to the fast strobe. A host-driven `clr_stb` zeroes the count and the flag together. The count is presented as a high byte and a low byte for a byte-wide register file.

Top module: `dtm_timer`

## Requirements
- R1: After reset, both count bytes read 0x00 and `slow_rate` reads 0.
- R2: While `dsg_active` is 0, neither the count nor `slow_rate` changes, whatever the tick inputs do.
- R3: With `slow_rate` at 0, `dsg_active` at 1 and a `tick_fast` pulse present, the count rises by one on the next clock edge. `tick_slow` has no effect on the count in this state.
- R4: With `slow_rate` at 1, the count rises by one per `tick_slow` pulse while `dsg_active` is 1. `tick_fast` has no effect on the count in this state.
- R5: An increment taken at 0xFFFF while `slow_rate` is 0 leaves the count at 0x0000 and sets `slow_rate` to 1.
- R6: An increment taken at 0xFFFF while `slow_rate` is 1 leaves the count at 0x0000 and clears `slow_rate` to 0. Later increments follow `tick_fast` again.
- R7: A cycle with `clr_stb` at 1 leaves the count at 0x0000 and `slow_rate` at 0 on the next edge, even if an increment was due in that cycle.
- R8: The count rises by at most one per clock cycle, even when both tick inputs are high together.
- R9: `cnt_hi` carries count bits 15..8 and `cnt_lo` carries bits 7..0. Outputs are registered, so each change shows one cycle after the inputs that cause it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dsg_active | input | 1 | High while the battery is discharging |
| tick_fast | input | 1 | Single-cycle strobe, 4096 per hour |
| tick_slow | input | 1 | Single-cycle strobe, 16 per hour |
| clr_stb | input | 1 | Zeroes count and status flag |
| cnt_hi | output | 8 | Count bits 15..8 |
| cnt_lo | output | 8 | Count bits 7..0 |
| slow_rate | output | 1 | High once the first overflow has switched to the slow strobe |

## Verification
The bench drives the full 16-bit count to 0xFFFF and steps across the first overflow. A design that only wrapped there would leave `slow_rate` low and keep following the fast strobe. It then checks that the unselected strobe is ignored in each rate state, and that a clear arriving together with a due increment wins. A faulty design would leave a count of 1 or keep the flag set. The second overflow is run on a narrower instance of the same RTL. That instance shows the flag dropping and the fast strobe taking effect again; a design that latched the flag would stay slow forever. Both ticks high together must still give only a single step.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  // Tick that drives the count in a given rate state
  function automatic logic pick_tick(input rate_e rate, input logic t_fast, input logic t_slow);
    return (rate == RATE_SLOW) ? t_slow : t_fast;
  endfunction

  // Rate state entered after an overflow
  function automatic rate_e rate_after_wrap(input rate_e rate);
    return (rate == RATE_SLOW) ? RATE_FAST : RATE_SLOW;
  endfunction

endpackage

// File: rtl/dtm_step_gate.sv
module dtm_step_gate
  import dtm_pkg::*;
(
  input  logic  dsg_active,
  input  logic  tick_fast,
  input  logic  tick_slow,
  input  logic  clr_stb,
  input  rate_e rate,
  output logic  step
);

  logic sel_tick;

  always_comb begin
    sel_tick = pick_tick(rate, tick_fast, tick_slow);
    step     = dsg_active && sel_tick && !clr_stb;
  end

endmodule

// File: rtl/dtm_count_reg.sv
module dtm_count_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_stb,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_ev
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] inc_wrap(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  assign wrap_ev = step && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_stb) cnt_q <= '0;
    else if (step)    cnt_q <= inc_wrap(cnt_q);
  end

  // R5 R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (cnt_q == '0));

endmodule

// File: rtl/dtm_rate_reg.sv
module dtm_rate_reg
  import dtm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_stb,
  input  logic  wrap_ev,
  output rate_e rate_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rate_q <= RATE_FAST;
    else if (clr_stb) rate_q <= RATE_FAST;
    else if (wrap_ev) rate_q <= rate_after_wrap(rate_q);
  end

  // R5
  first_wrap_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && rate_q == RATE_FAST && !clr_stb) |=> (rate_q == RATE_SLOW));

  // R6
  second_wrap_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && rate_q == RATE_SLOW && !clr_stb) |=> (rate_q == RATE_FAST));

endmodule

// File: rtl/dtm_timer.sv
module dtm_timer
  import dtm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsg_active,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              clr_stb,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic              slow_rate
);

  localparam int EXT_W = 2 * BYTE_W;

  logic             step;
  logic             wrap_ev;
  logic [CNT_W-1:0] cnt_q;
  rate_e            rate_q;
  logic [EXT_W-1:0] cnt_ext;

  dtm_step_gate u_gate (
    .dsg_active (dsg_active),
    .tick_fast  (tick_fast),
    .tick_slow  (tick_slow),
    .clr_stb    (clr_stb),
    .rate       (rate_q),
    .step       (step)
  );

  dtm_count_reg #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_stb (clr_stb),
    .step    (step),
    .cnt_q   (cnt_q),
    .wrap_ev (wrap_ev)
  );

  dtm_rate_reg u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_stb (clr_stb),
    .wrap_ev (wrap_ev),
    .rate_q  (rate_q)
  );

  // R9: byte split of the zero-extended count
  assign cnt_ext   = EXT_W'(cnt_q);
  assign cnt_hi    = cnt_ext[EXT_W-1:BYTE_W];
  assign cnt_lo    = cnt_ext[BYTE_W-1:0];
  assign slow_rate = (rate_q == RATE_SLOW);

  // R7
  clr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (cnt_q == '0 && !slow_rate));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsg_active && !clr_stb) |=> ($stable(cnt_q) && $stable(slow_rate)));

  // R8
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> ($stable(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R3
  fast_ignored_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_rate && !tick_fast && !clr_stb) |=> $stable(cnt_q));

  // R4
  slow_ignored_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_rate && !tick_slow && !clr_stb) |=> $stable(cnt_q));

endmodule

// File: tb/dtm_timer_bench.sv
module dtm_timer_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst_n = 1'b0;
  logic dsg = 1'b0, tf = 1'b0, ts = 1'b0, clr = 1'b0;
  logic [7:0] hi, lo;
  logic slw;

  logic nd = 1'b0, ntf = 1'b0, nts = 1'b0, nclr = 1'b0;
  logic [7:0] n_hi, n_lo;
  logic n_slw;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  dtm_timer u_dtm_timer (
    .clk(clk), .rst_n(rst_n), .dsg_active(dsg), .tick_fast(tf),
    .tick_slow(ts), .clr_stb(clr), .cnt_hi(hi), .cnt_lo(lo), .slow_rate(slw)
  );

  dtm_timer #(.CNT_W(10)) u_dtm_timer_narrow (
    .clk(clk), .rst_n(rst_n), .dsg_active(nd), .tick_fast(ntf),
    .tick_slow(nts), .clr_stb(nclr), .cnt_hi(n_hi), .cnt_lo(n_lo), .slow_rate(n_slw)
  );

  // {dsg, fast, slow, clr, expected count[15:0], expected slow flag}
  localparam int NV = 9;
  localparam logic [20:0] VECS [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 16'd1, 1'b0},  // R3 fast tick counts
    {1'b0, 1'b1, 1'b1, 1'b0, 16'd1, 1'b0},  // R2 no discharge, hold
    {1'b1, 1'b0, 1'b1, 1'b0, 16'd1, 1'b0},  // R3 slow tick ignored
    {1'b1, 1'b1, 1'b1, 1'b0, 16'd2, 1'b0},  // R8 both ticks, one step
    {1'b1, 1'b1, 1'b0, 1'b1, 16'd0, 1'b0},  // R7 clear beats increment
    {1'b1, 1'b1, 1'b0, 1'b0, 16'd1, 1'b0},  // R3
    {1'b1, 1'b0, 1'b0, 1'b0, 16'd1, 1'b0},  // R3 no tick, hold
    {1'b1, 1'b1, 1'b0, 1'b0, 16'd2, 1'b0},  // R3
    {1'b0, 1'b0, 1'b0, 1'b0, 16'd2, 1'b0}   // R2
  };

  task automatic check(input string req, input logic [15:0] act_cnt, input logic act_slw,
                       input logic [15:0] exp_cnt, input logic exp_slw);
    n_chk++;
    if (act_cnt !== exp_cnt || act_slw !== exp_slw) begin
      n_fail++;
      $display("FAIL %s: count=%h slow=%b expected count=%h slow=%b",
               req, act_cnt, act_slw, exp_cnt, exp_slw);
    end
  endtask

  task automatic check_main(input string req, input logic [15:0] exp_cnt, input logic exp_slw);
    check(req, {hi, lo}, slw, exp_cnt, exp_slw);
  endtask

  task automatic check_narrow(input string req, input logic [15:0] exp_cnt, input logic exp_slw);
    check(req, {n_hi, n_lo}, n_slw, exp_cnt, exp_slw);
  endtask

  // one cycle of main stimulus, then sample at the following negedge
  task automatic drive_main(input logic d, input logic f, input logic s, input logic c);
    dsg = d; tf = f; ts = s; clr = c;
    @(negedge clk);
    dsg = 1'b0; tf = 1'b0; ts = 1'b0; clr = 1'b0;
  endtask

  task automatic run_main_fast(input int n);
    dsg = 1'b1; tf = 1'b1;
    repeat (n) @(negedge clk);
    dsg = 1'b0; tf = 1'b0;
  endtask

  task automatic run_narrow(input logic use_slow, input int n);
    nd = 1'b1; ntf = !use_slow; nts = use_slow;
    repeat (n) @(negedge clk);
    nd = 1'b0; ntf = 1'b0; nts = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_main("R1 reset main", 16'h0000, 1'b0);
    check_narrow("R1 reset narrow", 16'h0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive_main(VECS[i][20], VECS[i][19], VECS[i][18], VECS[i][17]);
      check_main($sformatf("vector %0d (R2 R3 R7 R8 R9)", i), VECS[i][16:1], VECS[i][0]);
    end

    drive_main(1'b0, 1'b0, 1'b0, 1'b1);
    check_main("R7 clear from 2", 16'h0000, 1'b0);

    // R5 first overflow
    run_main_fast(65535);
    check_main("R5 at top, R9 bytes", 16'hFFFF, 1'b0);
    run_main_fast(1);
    check_main("R5 first rollover", 16'h0000, 1'b1);

    // R4 slow rate selection
    drive_main(1'b1, 1'b1, 1'b0, 1'b0);
    check_main("R4 fast tick ignored", 16'h0000, 1'b1);
    drive_main(1'b1, 1'b0, 1'b1, 1'b0);
    check_main("R4 slow tick counts", 16'h0001, 1'b1);
    drive_main(1'b1, 1'b1, 1'b1, 1'b0);
    check_main("R8 both ticks while slow", 16'h0002, 1'b1);
    drive_main(1'b0, 1'b0, 1'b1, 1'b0);
    check_main("R2 idle while slow", 16'h0002, 1'b1);

    // R7 clear with increment due while slow
    drive_main(1'b1, 1'b0, 1'b1, 1'b1);
    check_main("R7 clear wins, flag dropped", 16'h0000, 1'b0);
    drive_main(1'b1, 1'b1, 1'b0, 1'b0);
    check_main("R7 fast rate after clear", 16'h0001, 1'b0);

    // R6 second overflow on the 10-bit instance
    run_narrow(1'b0, 1023);
    check_narrow("R9 narrow top", 16'h03FF, 1'b0);
    run_narrow(1'b0, 1);
    check_narrow("R5 narrow first rollover", 16'h0000, 1'b1);
    run_narrow(1'b1, 1023);
    check_narrow("R4 narrow slow count", 16'h03FF, 1'b1);
    run_narrow(1'b1, 1);
    check_narrow("R6 second rollover", 16'h0000, 1'b0);
    run_narrow(1'b1, 1);
    check_narrow("R6 slow tick ignored after", 16'h0000, 1'b0);
    run_narrow(1'b0, 1);
    check_narrow("R6 fast rate restored", 16'h0001, 1'b0);

    finish_run();
  end

endmodule